// File: doc/BRIEF.md
# Set/Clear Aliased Transceiver Control Registers

This block is a small bank of control registers on the link side of a USB transceiver. It holds two byte-wide registers. The first configures the link interface: the protection circuit, fault-indicator handling, the 3-pin serial mode and clock power while that mode is in use. The second drives the OTG control lines: the VBUS drive, charge and discharge controls and the line pull resistors. Each register takes up three consecutive addresses. A write to the first address replaces the stored value. A write to the second ORs the data into it. A write to the third clears every bit that is 1 in the data. A read from any of the three addresses returns the stored value.

Hardware also acts on the bank. When 3-pin serial mode ends, the block clears the serial-mode bit on its own, and this clear wins over any software access in the same cycle. A clock-keep-on bit takes effect only in serial mode and only while the suspend control is high. An optional inversion turns the fault input into the fault indicator output. The register port is synchronous: address, write data and a write strobe, with read data registered one cycle after the address.

Top module: `phy_alias_regs`

## Requirements
- R1: After a synchronous reset, the link register (base 07h) reads 00h and the OTG register (base 0Ah) reads 06h. The dm_pulldown and dp_pulldown outputs are 1, all other field outputs are 0, and clk_pwr is 0.
- R2: A write to a register's base address (07h or 0Ah) replaces its writable bits with the write data.
- R3: A write to base+1 (08h or 0Bh) sets every bit that is 1 in the write data and leaves the other bits unchanged.
- R4: A write to base+2 (09h or 0Ch) clears every bit that is 1 in the write data and leaves the other bits unchanged.
- R5: reg_rdata, registered one cycle after reg_addr, shows the register value for any of its three addresses. It shows 0 for any unmapped address. Writes to unmapped addresses change nothing.
- R6: Bits 4, 2 and 0 of the link register are reserved. They always read 0, and write, set and clear operations ignore them.
- R7: While serial_exit is 1, the serial-mode bit (link bit 1, output serial3_en) is 0 after the next edge, even when a write or set to 1 arrives in the same cycle.
- R8: clk_pwr is 1 one cycle after the serial-mode bit (bit 1), the clock-keep-on bit (link bit 3) and suspend_n are all 1. Otherwise it is 0.
- R9: fault_ind is registered and equals fault_in XOR the complement bit (link bit 5, output fault_invert).
- R10: Field outputs follow the register bits. Link register: bit 7 iface_prot_off, bit 6 ind_passthru, bit 5 fault_invert, bit 1 serial3_en. OTG register: bit 7 ext_vbus_sel, bit 6 ext_vbus_drv, bit 5 vbus_drv, bit 4 vbus_chrg, bit 3 vbus_dischrg, bit 2 dm_pulldown, bit 1 dp_pulldown, bit 0 id_pullup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | AW (6) | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Registered read data |
| suspend_n | input | 1 | Suspend-mode control, 1 = not suspended |
| serial_exit | input | 1 | Pulse: 3-pin serial mode has ended |
| fault_in | input | 1 | External fault input |
| iface_prot_off | output | 1 | Interface protection disabled |
| ind_passthru | output | 1 | Indicator pass-through |
| fault_invert | output | 1 | Fault complement enable |
| serial3_en | output | 1 | 3-pin serial mode select |
| clk_pwr | output | 1 | Effective clock power in serial mode |
| fault_ind | output | 1 | Fault indicator (optionally inverted) |
| ext_vbus_sel | output | 1 | Use external VBUS indicator |
| ext_vbus_drv | output | 1 | External VBUS drive |
| vbus_drv | output | 1 | VBUS drive |
| vbus_chrg | output | 1 | VBUS charge |
| vbus_dischrg | output | 1 | VBUS discharge |
| dm_pulldown | output | 1 | D- pull-down enable |
| dp_pulldown | output | 1 | D+ pull-down enable |
| id_pullup | output | 1 | ID pull-up enable |

## Verification
On every cycle the assertions check several relations. The hardware serial-mode clear wins over software. clk_pwr and fault_ind follow their registered qualifiers. Reserved bits and unmapped addresses read zero. Set and clear aliases leave the addressed bits in the right state. The register reset values, the replace-versus-merge result of each alias on specific data patterns, and the mapping of each field onto its output pin only show up in the bench's vector table and directed scenarios. The same holds for the gating of clk_pwr by each qualifier in turn.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
  localparam int CFG_DW = 8;
  localparam int NREG   = 2;
  localparam int LINK_IDX = 0;
  localparam int OTG_IDX  = 1;

  // link register bit positions
  localparam int L_PROT_OFF  = 7;
  localparam int L_PASSTHRU  = 6;
  localparam int L_INVERT    = 5;
  localparam int L_CLK_KEEP  = 3;
  localparam int L_SERIAL3   = 1;

  localparam logic [CFG_DW-1:0] LINK_RST  = 8'h00;
  localparam logic [CFG_DW-1:0] LINK_MASK = 8'hEA;
  localparam logic [CFG_DW-1:0] OTG_RST   = 8'h06;
  localparam logic [CFG_DW-1:0] OTG_MASK  = 8'hFF;

  function automatic logic [CFG_DW-1:0] reg_rst(int idx);
    return (idx == LINK_IDX) ? LINK_RST : OTG_RST;
  endfunction

  function automatic logic [CFG_DW-1:0] reg_mask(int idx);
    return (idx == LINK_IDX) ? LINK_MASK : OTG_MASK;
  endfunction
endpackage

// File: rtl/cfg_alias_reg.sv
module cfg_alias_reg #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [DW-1:0] RST_VAL = '0,
  parameter logic [DW-1:0] WMASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  input  logic [DW-1:0] hw_clr,
  output logic [DW-1:0] q,
  output logic          hit
);
  localparam logic [AW-1:0] SET_A = BASE + AW'(1);
  localparam logic [AW-1:0] CLR_A = BASE + AW'(2);

  logic [DW-1:0] nxt;

  always_comb begin
    hit = (addr == BASE) || (addr == SET_A) || (addr == CLR_A);
    nxt = q;
    if (we) begin
      if (addr == BASE)       nxt = wdata;
      else if (addr == SET_A) nxt = q | wdata;
      else if (addr == CLR_A) nxt = q & ~wdata;
    end
    nxt = nxt & WMASK & ~hw_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= nxt;
  end
endmodule

// File: rtl/phy_side_fx.sv
module phy_side_fx (
  input  logic clk,
  input  logic rst,
  input  logic serial_on,
  input  logic clk_keep,
  input  logic suspend_n,
  input  logic fault_in,
  input  logic invert,
  output logic clk_pwr,
  output logic fault_ind
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_pwr   <= 1'b0;
      fault_ind <= 1'b0;
    end else begin
      clk_pwr   <= serial_on & suspend_n & clk_keep;
      fault_ind <= fault_in ^ invert;
    end
  end
endmodule

// File: rtl/phy_alias_regs.sv
module phy_alias_regs
  import phy_cfg_pkg::*;
#(
  parameter int AW        = 6,
  parameter int LINK_BASE = 7,
  parameter int OTG_BASE  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_we,
  output logic [7:0]    reg_rdata,
  input  logic          suspend_n,
  input  logic          serial_exit,
  input  logic          fault_in,
  output logic          iface_prot_off,
  output logic          ind_passthru,
  output logic          fault_invert,
  output logic          serial3_en,
  output logic          clk_pwr,
  output logic          fault_ind,
  output logic          ext_vbus_sel,
  output logic          ext_vbus_drv,
  output logic          vbus_drv,
  output logic          vbus_chrg,
  output logic          vbus_dischrg,
  output logic          dm_pulldown,
  output logic          dp_pulldown,
  output logic          id_pullup
);
  logic [CFG_DW-1:0] cfg_q  [NREG];
  logic [CFG_DW-1:0] hw_clr [NREG];
  logic [NREG-1:0]   hit;
  logic [CFG_DW-1:0] rd_nxt;
  logic [CFG_DW-1:0] link_q;
  logic [CFG_DW-1:0] otg_q;

  always_comb begin
    hw_clr[LINK_IDX] = '0;
    hw_clr[LINK_IDX][L_SERIAL3] = serial_exit;
    hw_clr[OTG_IDX] = '0;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int BASE_I = (g == LINK_IDX) ? LINK_BASE : OTG_BASE;
    cfg_alias_reg #(
      .DW(CFG_DW), .AW(AW),
      .BASE(AW'(BASE_I)),
      .RST_VAL(reg_rst(g)),
      .WMASK(reg_mask(g))
    ) u_reg (
      .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata),
      .we(reg_we), .hw_clr(hw_clr[g]), .q(cfg_q[g]), .hit(hit[g])
    );
  end

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rd_nxt = rd_nxt | cfg_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end

  assign link_q = cfg_q[LINK_IDX];
  assign otg_q  = cfg_q[OTG_IDX];

  assign iface_prot_off = link_q[L_PROT_OFF];
  assign ind_passthru   = link_q[L_PASSTHRU];
  assign fault_invert   = link_q[L_INVERT];
  assign serial3_en     = link_q[L_SERIAL3];
  assign {ext_vbus_sel, ext_vbus_drv, vbus_drv, vbus_chrg,
          vbus_dischrg, dm_pulldown, dp_pulldown, id_pullup} = otg_q;

  phy_side_fx u_fx (
    .clk(clk), .rst(rst),
    .serial_on(link_q[L_SERIAL3]), .clk_keep(link_q[L_CLK_KEEP]),
    .suspend_n(suspend_n), .fault_in(fault_in), .invert(link_q[L_INVERT]),
    .clk_pwr(clk_pwr), .fault_ind(fault_ind)
  );
endmodule

// File: rtl/phy_alias_regs_chk.sv
module phy_alias_regs_chk #(
  parameter int AW        = 6,
  parameter int LINK_BASE = 7,
  parameter int OTG_BASE  = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          reg_we,
  input logic [7:0]    reg_rdata,
  input logic          suspend_n,
  input logic          serial_exit,
  input logic          fault_in,
  input logic          serial3_en,
  input logic          fault_invert,
  input logic          clk_pwr,
  input logic          fault_ind,
  input logic [7:0]    link_q
);
  localparam logic [AW-1:0] L0 = AW'(LINK_BASE);
  localparam logic [AW-1:0] L1 = AW'(LINK_BASE + 1);
  localparam logic [AW-1:0] L2 = AW'(LINK_BASE + 2);
  localparam logic [AW-1:0] O0 = AW'(OTG_BASE);
  localparam logic [AW-1:0] O2 = AW'(OTG_BASE + 2);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  logic link_hit, any_hit;
  assign link_hit = (reg_addr >= L0) && (reg_addr <= L2);
  assign any_hit  = link_hit || ((reg_addr >= O0) && (reg_addr <= O2));

  // R7: hardware clear of serial mode wins
  a_r7_hw_clear_wins: assert property (@(posedge clk) disable iff (rst)
    serial_exit |=> !serial3_en);

  // R8: clock power only with all three qualifiers
  a_r8_clk_gate: assert property (@(posedge clk) disable iff (rst)
    armed |-> (clk_pwr == $past(serial3_en && suspend_n && link_q[3])));

  // R9: fault indicator follows input and complement
  a_r9_fault_xor: assert property (@(posedge clk) disable iff (rst)
    armed |-> (fault_ind == $past(fault_in ^ fault_invert)));

  // R6: reserved bits of link register read zero
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(link_hit)) |-> ((reg_rdata & 8'h15) == 8'h00));

  // R5: unmapped address reads zero
  a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(any_hit)) |-> (reg_rdata == 8'h00));

  // R4: clear alias leaves addressed bits clear
  a_r4_clear_alias: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(reg_we && reg_addr == L2)) |-> ((link_q & $past(reg_wdata)) == 8'h00));

  // R3: set alias leaves writable addressed bits set
  a_r3_set_alias: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(reg_we && reg_addr == L1 && !serial_exit)) |->
      ((link_q & $past(reg_wdata) & 8'hEA) == ($past(reg_wdata) & 8'hEA)));
endmodule

bind phy_alias_regs phy_alias_regs_chk #(
  .AW(AW), .LINK_BASE(LINK_BASE), .OTG_BASE(OTG_BASE)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_we(reg_we), .reg_rdata(reg_rdata), .suspend_n(suspend_n),
  .serial_exit(serial_exit), .fault_in(fault_in), .serial3_en(serial3_en),
  .fault_invert(fault_invert), .clk_pwr(clk_pwr), .fault_ind(fault_ind),
  .link_q(link_q)
);

// File: tb/test_phy_alias_regs.sv
module test_phy_alias_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic suspend_n = 1'b1, serial_exit = 1'b0, fault_in = 1'b0;
  logic iface_prot_off, ind_passthru, fault_invert, serial3_en, clk_pwr, fault_ind;
  logic ext_vbus_sel, ext_vbus_drv, vbus_drv, vbus_chrg, vbus_dischrg;
  logic dm_pulldown, dp_pulldown, id_pullup;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phy_alias_regs i_phy_alias_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .suspend_n(suspend_n),
    .serial_exit(serial_exit), .fault_in(fault_in),
    .iface_prot_off(iface_prot_off), .ind_passthru(ind_passthru),
    .fault_invert(fault_invert), .serial3_en(serial3_en), .clk_pwr(clk_pwr),
    .fault_ind(fault_ind), .ext_vbus_sel(ext_vbus_sel),
    .ext_vbus_drv(ext_vbus_drv), .vbus_drv(vbus_drv), .vbus_chrg(vbus_chrg),
    .vbus_dischrg(vbus_dischrg), .dm_pulldown(dm_pulldown),
    .dp_pulldown(dp_pulldown), .id_pullup(id_pullup)
  );

  typedef struct packed {
    logic [5:0] waddr;
    logic [7:0] wdata;
    logic [5:0] raddr;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{6'h07, 8'hFF, 6'h07, 8'hEA, 4'd2},  // R2 with R6 masking
    '{6'h09, 8'h0A, 6'h08, 8'hE0, 4'd4},  // R4 read via set alias
    '{6'h08, 8'h1F, 6'h09, 8'hEA, 4'd3},  // R3 with reserved ignored
    '{6'h0A, 8'h5A, 6'h0C, 8'h5A, 4'd2},  // R2 OTG
    '{6'h0B, 8'h81, 6'h0A, 8'hDB, 4'd3},  // R3 OTG
    '{6'h0C, 8'h0F, 6'h0B, 8'hD0, 4'd4},  // R4 OTG
    '{6'h07, 8'h20, 6'h07, 8'h20, 4'd2},  // R2 replace
    '{6'h0D, 8'hFF, 6'h0D, 8'h00, 4'd5},  // R5 unmapped read
    '{6'h06, 8'hFF, 6'h07, 8'h20, 4'd5},  // R5 unmapped write no effect
    '{6'h0A, 8'h06, 6'h0A, 8'h06, 4'd2}   // R2 OTG back to reset pattern
  };

  function automatic string req_name(logic [3:0] r);
    case (r)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    rd(6'h07, v); chk("R1", v, 8'h00);
    rd(6'h0A, v); chk("R1", v, 8'h06);
    chk("R1", {ext_vbus_sel, ext_vbus_drv, vbus_drv, vbus_chrg, vbus_dischrg,
               dm_pulldown, dp_pulldown, id_pullup}, 8'h06);
    chk("R1", {4'b0, iface_prot_off, ind_passthru, fault_invert, serial3_en}, 8'h00);
    chk("R1", {6'b0, clk_pwr, fault_ind}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].waddr, VECS[i].wdata);
      rd(VECS[i].raddr, v);
      chk(req_name(VECS[i].req), v, VECS[i].exp);
    end

    // R10: field mapping
    wr(6'h07, 8'hC0);
    chk("R10", {iface_prot_off, ind_passthru, fault_invert, serial3_en}, 4'b1100);
    wr(6'h07, 8'h22);
    chk("R10", {iface_prot_off, ind_passthru, fault_invert, serial3_en}, 4'b0011);
    wr(6'h0A, 8'hA5);
    chk("R10", {ext_vbus_sel, ext_vbus_drv, vbus_drv, vbus_chrg, vbus_dischrg,
                dm_pulldown, dp_pulldown, id_pullup}, 8'hA5);

    // R9: fault indicator
    wr(6'h07, 8'h00);
    fault_in = 1'b1; @(negedge clk);
    chk("R9", {7'b0, fault_ind}, 8'h01);
    wr(6'h08, 8'h20); @(negedge clk);
    chk("R9", {7'b0, fault_ind}, 8'h00);
    fault_in = 1'b0; @(negedge clk);
    chk("R9", {7'b0, fault_ind}, 8'h01);

    // R8: clock power gating
    suspend_n = 1'b1;
    wr(6'h07, 8'h0A); @(negedge clk);
    chk("R8", {7'b0, clk_pwr}, 8'h01);
    suspend_n = 1'b0; @(negedge clk);
    chk("R8", {7'b0, clk_pwr}, 8'h00);
    suspend_n = 1'b1; @(negedge clk);
    chk("R8", {7'b0, clk_pwr}, 8'h01);
    wr(6'h07, 8'h08); @(negedge clk);
    chk("R8", {7'b0, clk_pwr}, 8'h00);
    wr(6'h07, 8'h02); @(negedge clk);
    chk("R8", {7'b0, clk_pwr}, 8'h00);

    // R7: hardware clear of serial mode
    chk("R7", {7'b0, serial3_en}, 8'h01);
    serial_exit = 1'b1; @(negedge clk); serial_exit = 1'b0;
    chk("R7", {7'b0, serial3_en}, 8'h00);
    rd(6'h07, v); chk("R7", v, 8'h00);
    serial_exit = 1'b1;
    wr(6'h08, 8'h0A);
    serial_exit = 1'b0;
    chk("R7", {7'b0, serial3_en}, 8'h00);
    rd(6'h09, v); chk("R7", v, 8'h08);

    // R6: reserved bits after set of all ones
    wr(6'h08, 8'hFF);
    rd(6'h08, v); chk("R6", v, 8'hEA);

    // R1: reset restores defaults
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    rd(6'h07, v); chk("R1", v, 8'h00);
    rd(6'h0C, v); chk("R1", v, 8'h06);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule